// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the timekeeping core of a real-time clock. It holds seven calendar fields as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month, two-digit year (2000 to 2099) and weekday. The fields advance once per second. A second lasts `PRESCALE` pulses of a tick enable, which runs at 32.768 kHz in the real system. Day-of-month rollover follows the length of the current month, and February has 29 days in leap years.

Software reaches the block through a byte-wide register bus. Reads are combinational and writes are single-cycle. A control register holds the run bit and a few stored mode bits. A status register reports the following:
- the run state;
- a busy window during the tick period that leads into each one-second update;
- sticky rollover events for the second, minute, hour and day;
- an alarm flag raised by an external pulse.

All the sticky flags clear when 1 is written to them. Software waits for busy to drop and then has most of a second to read or set the time. Setting any time field also restarts the sub-second count.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, 00 hours, day 01, month 01, year 00 and weekday 06. Control reads 0x00 and status reads 0x00.
- R2: The fields sit at byte addresses 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year and 0x18 weekday. A write stores the byte masked to 0x7F, 0x7F, 0x3F, 0x3F, 0x1F, 0xFF and 0x07 respectively, and the stored value reads back at once.
- R3: Control sits at 0x40. Bit 0 is the run bit: the fields and the sub-second count advance only while it is 1. Status bit 1 (status at 0x44) mirrors it.
- R4: One second passes after `PRESCALE` tick enables seen while running. A write to any time field clears the sub-second count, so the next second needs a full `PRESCALE` ticks.
- R5: Status bit 0 (busy) is 1 exactly while running with the sub-second count at its last value, which is the tick period just before the seconds update. A field changes only after a busy cycle or a write.
- R6: Seconds and minutes count in BCD from 00 to 59. Each wrap from 59 to 00 carries into the next field.
- R7: Hours count from 00 to 23 and wrap to 00, carrying into the day and weekday. Control bit 3 is stored but counting stays 24-hour.
- R8: The day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In February it wraps after 28, or after 29 when the BCD year is divisible by 4.
- R9: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R10: The weekday advances with each day rollover and wraps from 6 to 0.
- R11: Status bits 2, 3, 4 and 5 are set on second, minute, hour and day rollovers. They stay set until 1 is written to them, and writing 0 leaves them unchanged.
- R12: Status bit 6 is set by an `alarm_evt` pulse and cleared by writing 1 to it. A set in the same cycle as a clear wins.
- R13: Control bits 7, 3, 2 and 0 read back as written and the other control bits read 0. Status bit 7 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz period |
| alarm_evt | input | 1 | Pulse that sets the alarm flag |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
Read data is combinational, so the bench sets the address half a cycle before an edge and compares after a short settle inside the same cycle. A write or an alarm pulse applied for one cycle is visible on the first read after the edge that captured it. A tick enable seen at an edge advances the model in the same step, so the seconds update appears after the `PRESCALE`-th tick edge. Busy appears after the edge of tick `PRESCALE-1`. The bench drives stimulus on falling edges and updates its model for each rising edge that will capture that stimulus, so every comparison lands on the cycle in which the register can first have changed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned FLD_N      = 7;
  localparam int unsigned FLD_STRIDE = 4;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_DAY  = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YR   = 5;
  localparam int unsigned F_WDAY = 6;

  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h44;
  localparam logic [7:0] CTRL_MASK = 8'h8D;

  // index 6 (weekday) first
  localparam logic [FLD_N-1:0][7:0] FLD_MASK =
    {8'h07, 8'hFF, 8'h1F, 8'h3F, 8'h3F, 8'h7F, 8'h7F};
  localparam logic [FLD_N-1:0][7:0] FLD_RST =
    {8'h06, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6
  function automatic logic leap_bcd(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clear,
  output logic busy_o,
  output logic sec_pulse_o
);

  localparam int unsigned CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  assign at_max      = (cnt_q == CNT_MAX);
  assign busy_o      = run && at_max;
  assign sec_pulse_o = run && tick_en && at_max && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                cnt_d = '0;
    else if (run && tick_en)  cnt_d = at_max ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: after the carry the busy window is over (PRESCALE >= 2)
  p_busy_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse_o |=> !busy_o);

  // R4: a field write restarts the second
  p_clear_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_pulse,
  input  logic [FLD_N-1:0]          wr_en,
  input  logic [7:0]                wdata,
  output logic [FLD_N-1:0][7:0]     fld_o,
  output logic [3:0]                ev_o
);

  logic [FLD_N-1:0][7:0] fld_q, fld_d;
  logic [3:0]            ev;

  always_comb begin
    fld_d = fld_q;
    ev    = '0;
    if (sec_pulse) begin
      ev[0] = 1'b1;
      if (fld_q[F_SEC] == 8'h59) begin
        fld_d[F_SEC] = 8'h00;
        ev[1]        = 1'b1;
        if (fld_q[F_MIN] == 8'h59) begin
          fld_d[F_MIN] = 8'h00;
          ev[2]        = 1'b1;
          if (fld_q[F_HR] == 8'h23) begin
            fld_d[F_HR]   = 8'h00;
            ev[3]         = 1'b1;
            fld_d[F_WDAY] = (fld_q[F_WDAY] == 8'h06) ? 8'h00 : bcd_inc(fld_q[F_WDAY]);
            if (fld_q[F_DAY] == last_day(fld_q[F_MON], fld_q[F_YR])) begin
              fld_d[F_DAY] = 8'h01;
              if (fld_q[F_MON] == 8'h12) begin
                fld_d[F_MON] = 8'h01;
                fld_d[F_YR]  = (fld_q[F_YR] == 8'h99) ? 8'h00 : bcd_inc(fld_q[F_YR]);
              end else begin
                fld_d[F_MON] = bcd_inc(fld_q[F_MON]);
              end
            end else begin
              fld_d[F_DAY] = bcd_inc(fld_q[F_DAY]);
            end
          end else begin
            fld_d[F_HR] = bcd_inc(fld_q[F_HR]);
          end
        end else begin
          fld_d[F_MIN] = bcd_inc(fld_q[F_MIN]);
        end
      end else begin
        fld_d[F_SEC] = bcd_inc(fld_q[F_SEC]);
      end
    end
    for (int i = 0; i < FLD_N; i++) begin
      if (wr_en[i]) fld_d[i] = wdata & FLD_MASK[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= FLD_RST;
    else        fld_q <= fld_d;
  end

  assign fld_o = fld_q;
  assign ev_o  = ev;

  p_sec_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && fld_q[F_SEC] == 8'h59 && wr_en == '0) |=> (fld_q[F_SEC] == 8'h00));

  p_hr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && fld_q[F_SEC] == 8'h59 && fld_q[F_MIN] == 8'h59 &&
     fld_q[F_HR] == 8'h23 && wr_en == '0) |=> (fld_q[F_HR] == 8'h00));

  p_wday_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o[3] && fld_q[F_WDAY] == 8'h06 && wr_en == '0) |=> (fld_q[F_WDAY] == 8'h00));

  p_year_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o[3] && fld_q[F_DAY] == 8'h31 && fld_q[F_MON] == 8'h12 &&
     fld_q[F_YR] == 8'h99 && wr_en == '0) |=> (fld_q[F_YR] == 8'h00 && fld_q[F_MON] == 8'h01));

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ev_i,
  input  logic       alarm_i,
  input  logic [4:0] clr_mask,
  output logic [4:0] flags_o
);

  // flags_o maps to status bits 6:2 = {alarm, day, hour, minute, second}
  logic [4:0] flags_q, flags_d;

  always_comb begin
    flags_d = (flags_q & ~clr_mask) | {alarm_i, ev_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[0] && !ev_i[0]) |=> !flags_q[0]);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == 5'd0 && flags_q[1]) |=> flags_q[1]);

  p_alarm_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_i |=> flags_q[4]);

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       alarm_evt,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  logic [FLD_N-1:0]      time_wr;
  logic                  ctrl_wr, stat_wr;
  logic [7:0]            ctrl_q, ctrl_d;
  logic                  run;
  logic                  busy, sec_pulse;
  logic [FLD_N-1:0][7:0] fld;
  logic [3:0]            ev;
  logic [4:0]            flags;
  logic [4:0]            clr_mask;

  for (genvar gi = 0; gi < FLD_N; gi++) begin : g_dec
    assign time_wr[gi] = bus_wr && (bus_addr == 8'(gi * FLD_STRIDE));
  end

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
  assign stat_wr  = bus_wr && (bus_addr == ADDR_STAT);
  assign clr_mask = stat_wr ? bus_wdata[6:2] : 5'd0;
  assign run      = ctrl_q[0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = bus_wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .run         (run),
    .clear       (|time_wr),
    .busy_o      (busy),
    .sec_pulse_o (sec_pulse)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .wr_en     (time_wr),
    .wdata     (bus_wdata),
    .fld_o     (fld),
    .ev_o      (ev)
  );

  rtc_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev),
    .alarm_i  (alarm_evt),
    .clr_mask (clr_mask),
    .flags_o  (flags)
  );

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < FLD_N; i++) begin
      if (bus_addr == 8'(i * FLD_STRIDE)) bus_rdata = fld[i];
    end
    if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_STAT) bus_rdata = {1'b0, flags, run, busy};
  end

  // R3: stopped counter keeps seconds unless software writes
  p_stop_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && time_wr == '0) |=> $stable(fld[F_SEC]));

  // R5: seconds move only out of a busy cycle or by a write
  p_sec_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fld[F_SEC]) |-> $past(busy || time_wr[F_SEC]));

endmodule

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;

  localparam int CLK_P = 10;
  localparam int PRE   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       alarm_evt = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int ms, mm, mh, md, mo, my, mw, mp, mrun, mctrl, mflags;

  bcd_rtc_core #(.PRESCALE(PRE)) i_bcd_rtc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .alarm_evt (alarm_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_second();
    mflags |= 32'h04; ms++;
    if (ms == 60) begin
      ms = 0; mflags |= 32'h08; mm++;
      if (mm == 60) begin
        mm = 0; mflags |= 32'h10; mh++;
        if (mh == 24) begin
          mh = 0; mflags |= 32'h20;
          mw = (mw == 6) ? 0 : mw + 1;
          md++;
          if (md > days_in(mo, my)) begin
            md = 1; mo++;
            if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    bus_addr = addr;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic bus_write(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (addr == 8'h40) begin mctrl = int'(data & 8'h8D); mrun = int'(data[0]); end
    else if (addr == 8'h44) mflags &= ~int'(data & 8'h7C);
    else if (addr <= 8'h18 && addr[1:0] == 2'b00) mp = 0;
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int d,
                          input int mon, input int y, input int w);
    bus_write(8'h00, to_bcd(s));   ms = s;
    bus_write(8'h04, to_bcd(mi));  mm = mi;
    bus_write(8'h08, to_bcd(h));   mh = h;
    bus_write(8'h0C, to_bcd(d));   md = d;
    bus_write(8'h10, to_bcd(mon)); mo = mon;
    bus_write(8'h14, to_bcd(y));   my = y;
    bus_write(8'h18, to_bcd(w));   mw = w;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      if (mrun != 0) begin
        if (mp == PRE - 1) begin mp = 0; model_second(); end
        else mp++;
      end
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_status();
    int v;
    v = mflags | (mrun << 1) | ((mrun != 0 && mp == PRE - 1) ? 1 : 0);
    return 8'(v);
  endfunction

  task automatic check_all(input string tag);
    rd_chk(8'h00, to_bcd(ms), {tag, " R6 seconds"});
    rd_chk(8'h04, to_bcd(mm), {tag, " R6 minutes"});
    rd_chk(8'h08, to_bcd(mh), {tag, " R7 hours"});
    rd_chk(8'h0C, to_bcd(md), {tag, " R8 day"});
    rd_chk(8'h10, to_bcd(mo), {tag, " R9 month"});
    rd_chk(8'h14, to_bcd(my), {tag, " R9 year"});
    rd_chk(8'h18, to_bcd(mw), {tag, " R10 weekday"});
    rd_chk(8'h40, 8'(mctrl), {tag, " R13 control"});
    rd_chk(8'h44, exp_status(), {tag, " R11 R5 status"});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    ms = 0; mm = 0; mh = 0; md = 1; mo = 1; my = 0; mw = 6;
    mp = 0; mrun = 0; mctrl = 0; mflags = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset");

    // R2 masks, run off
    bus_write(8'h00, 8'hFF); rd_chk(8'h00, 8'h7F, "R2 mask sec");
    bus_write(8'h04, 8'hFF); rd_chk(8'h04, 8'h7F, "R2 mask min");
    bus_write(8'h08, 8'hFF); rd_chk(8'h08, 8'h3F, "R2 mask hour");
    bus_write(8'h0C, 8'hFF); rd_chk(8'h0C, 8'h3F, "R2 mask day");
    bus_write(8'h10, 8'hFF); rd_chk(8'h10, 8'h1F, "R2 mask month");
    bus_write(8'h14, 8'hFF); rd_chk(8'h14, 8'hFF, "R2 mask year");
    bus_write(8'h18, 8'hFF); rd_chk(8'h18, 8'h07, "R2 mask weekday");
    rd_chk(8'h30, 8'h00, "R13 unmapped");

    // R3 stopped: ticks have no effect
    set_time(10, 20, 5, 15, 6, 24, 3);
    tick(3 * PRE);
    check_all("R3 stopped");

    // R13 stored control bits, 24-hour counting kept (R7)
    bus_write(8'h40, 8'hFF);
    check_all("R13 ctrl mask");
    set_time(59, 59, 12, 10, 3, 30, 1);
    tick(PRE);
    check_all("R7 hour past 12 with bit3");
    rd_chk(8'h08, 8'h13, "R7 hour 13");

    // R4/R5: busy after PRE-1 ticks, carry on the PRE-th
    bus_write(8'h40, 8'h01);
    set_time(30, 0, 0, 1, 1, 0, 0);
    tick(PRE - 1);
    rd_chk(8'h44, exp_status(), "R5 busy window");
    rd_chk(8'h00, 8'h30, "R4 not yet");
    tick(1);
    rd_chk(8'h00, 8'h31, "R4 one second");
    rd_chk(8'h44, exp_status(), "R5 busy dropped");
    tick(PRE - 1);
    bus_write(8'h04, 8'h07); mm = 7;
    tick(PRE - 1);
    check_all("R4 write restarts second");
    tick(1);
    check_all("R4 full second after write");

    // R11 W1C of events, zero write no effect
    bus_write(8'h44, 8'h00);
    check_all("R11 zero write");
    bus_write(8'h44, 8'h3C);
    check_all("R11 w1c");

    // directed calendar corners
    set_time(59, 59, 23, 28, 2, 23, 6);   tick(PRE); check_all("R8 feb non-leap");
    set_time(59, 59, 23, 28, 2, 24, 2);   tick(PRE); check_all("R8 feb leap 28");
    set_time(59, 59, 23, 29, 2, 24, 3);   tick(PRE); check_all("R8 feb leap 29");
    set_time(59, 59, 23, 30, 4, 50, 5);   tick(PRE); check_all("R8 april");
    set_time(59, 59, 23, 30, 1, 50, 5);   tick(PRE); check_all("R8 jan 30");
    set_time(59, 59, 23, 31, 12, 99, 6);  tick(PRE); check_all("R9 R10 year wrap");
    set_time(59, 59, 23, 31, 12, 41, 4);  tick(PRE); check_all("R9 month wrap");
    bus_write(8'h44, 8'h7C);

    // R12 alarm
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0; mflags |= 32'h40;
    check_all("R12 alarm set");
    @(negedge clk);
    bus_addr = 8'h44; bus_wdata = 8'h40; bus_wr = 1'b1; alarm_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; alarm_evt = 1'b0;
    check_all("R12 set wins");
    bus_write(8'h44, 8'h40);
    check_all("R12 w1c");

    // random
    for (int it = 0; it < 60; it++) begin
      int s, mi, h, d, mon, y, w;
      mon = 1 + int'($urandom % 12);
      y   = int'($urandom % 100);
      s   = ($urandom % 2) ? 59 : int'($urandom % 60);
      mi  = ($urandom % 2) ? 59 : int'($urandom % 60);
      h   = ($urandom % 2) ? 23 : int'($urandom % 24);
      d   = ($urandom % 2) ? days_in(mon, y) : 1 + int'($urandom % days_in(mon, y));
      w   = int'($urandom % 7);
      bus_write(8'h40, ($urandom % 6 == 0) ? 8'h00 : 8'h01);
      set_time(s, mi, h, d, mon, y, w);
      tick(1 + int'($urandom % (3 * PRE)));
      check_all("R6 R8 R9 random");
      if ($urandom % 2) bus_write(8'h44, 8'(($urandom % 32) << 2));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule